// File: doc/BRIEF.md
# Speculative Fetch Gate

This block sits between an instruction prefetch queue and the memory fetch port. Each cycle it looks at a short window of predecoded instructions ahead of the fetch point. It then decides what the next speculative fetch should be. It can be the target of a register-indirect branch: the count-register form takes its target from `ctr_val`, and the link-register form from `lr_val`. Otherwise it is the next sequential address. In some cases the gate holds the fetcher in a stall, or parks it behind a branch-to-self. A branch target is not fetched when an older instruction in the window may still change the register it reads, or when an older trap stands in front of the branch. System-call and interrupt-return instructions do not block a prediction.

A fixed table of address ranges gives each fetch address a guarded bit. The table has four entries by default, and the lowest-numbered matching entry wins. No speculative fetch is ever issued into a guarded range. A fetch is allowed to an address that matches no entry, but that address is invalid, so the fetch raises a pending machine-check flag. The flag turns into a one-cycle raise pulse only when the fetched instruction is reported as executed. A flush drops the flag without a raise.

All outputs are registered. Each decision appears one clock after the inputs it was made from.

Top module: `sfg_gate`

## Requirements
- R1: `win_op` holds four bits per slot: slot i is `win_op[4i+3:4i]`, and slot 0 is the oldest. A slot counts only when its bit in `win_valid` is 1. Codes: 0 other, 1 branch-to-count, 2 branch-to-link, 3 move-to-count, 4 move-from-count, 5 move-to-link, 6 trap (register or immediate form), 7 unconditional branch-to-self, 8 system call or interrupt return. When the window has no valid code 1, 2 or 7, the gate fetches `seq_addr` sequentially, with `fetch_indirect` = 0, provided that address is not guarded.
- R2: No fetch is issued to a guarded address. When the chosen address is guarded, the gate asserts `stall` and leaves `fetch_req` at 0. This holds for sequential fetches and for indirect targets.
- R3: The oldest valid indirect branch selects the target: code 1 fetches `ctr_val` and code 2 fetches `lr_val`, with `fetch_indirect` = 1.
- R4: A valid code 3 or 4 older than a code 1 makes the gate stall instead of fetching. A code 5 does not block a code 1.
- R5: A valid code 5 older than a code 2 makes the gate stall. Codes 3 and 4 do not block a code 2.
- R6: A valid code 6 older than either indirect branch makes the gate stall.
- R7: Code 8 never blocks a prediction. It acts like code 0.
- R8: A valid code 7 that is older than every valid indirect branch, or that stands in a window with no indirect branch, sets `hang`. It also forces `fetch_req` = 0 and `stall` = 0.
- R9: Blocking instructions younger than the selected indirect branch are ignored, and so are slots whose valid bit is 0.
- R10: Default ranges, lowest index first: 0x0000–0x0FFF open, 0x1000–0x10FF guarded, 0x2000–0x7FFF open, 0x7000–0xFFFF guarded. An address matching no range is fetched and sets `mchk_pend` on the same clock as the fetch.
- R11: If `exec_commit` is high while `mchk_pend` is 1, `mchk_raise` pulses high on the next cycle and `mchk_pend` clears, unless a new invalid fetch sets it again.
- R12: A cycle with `flush` high makes `fetch_req`, `stall`, `hang`, `mchk_pend` and `mchk_raise` all 0 on the next cycle.
- R13: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Window flushed; clears decision and machine-check state |
| win_valid | input | 4 | Valid bit per window slot |
| win_op | input | 16 | Predecoded class per slot, slot 0 oldest |
| seq_addr | input | 16 | Next sequential fetch address |
| ctr_val | input | 16 | Current count register value |
| lr_val | input | 16 | Current link register value |
| exec_commit | input | 1 | The instruction from the last invalid fetch reached execution |
| fetch_req | output | 1 | Speculative fetch issued |
| fetch_addr | output | 16 | Address of the fetch |
| fetch_indirect | output | 1 | Fetch is an indirect-branch target |
| stall | output | 1 | Fetch suppressed, waiting for the window to change |
| hang | output | 1 | Fetching parked behind a branch-to-self |
| mchk_pend | output | 1 | Deferred machine check recorded |
| mchk_raise | output | 1 | Machine check becomes an exception |

## Verification
Every fetch decision (`fetch_req`, `fetch_addr`, `fetch_indirect`, `stall`, `hang`) depends on the window and the addresses one register stage earlier. The bench therefore drives on a falling edge and compares on the next falling edge, one rising edge later. `mchk_pend` is set on the same edge as the fetch that caused it. `mchk_raise` and the clearing of the flag come one edge after `exec_commit`, so the bench checks them on the falling edge after the commit cycle. The same one-edge rule applies to flush, which is checked on the falling edge after the flush cycle.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_OTHER  = 4'd0,
      OP_BCTR   = 4'd1,
      OP_BLR    = 4'd2,
      OP_MTCTR  = 4'd3,
      OP_MFCTR  = 4'd4,
      OP_MTLR   = 4'd5,
      OP_TRAP   = 4'd6,
      OP_BSELF  = 4'd7,
      OP_SYSRET = 4'd8
   } sfg_op_e;

   typedef struct packed {
      logic found;
      logic use_ctr;
      logic blocked;
      logic hang;
   } sfg_scan_t;
endpackage

// File: rtl/sfg_window_scan.sv
module sfg_window_scan
   import sfg_pkg::*;
#(
   parameter int WIN_DEPTH = 4
) (
   input  logic [WIN_DEPTH-1:0]      win_valid,
   input  logic [WIN_DEPTH*OP_W-1:0] win_op,
   output sfg_scan_t                 scan
);
   localparam int OPS_W = WIN_DEPTH * OP_W;

   generate
      if (WIN_DEPTH < 1 || WIN_DEPTH > 16) begin : g_bad_depth
         $error("sfg_window_scan: WIN_DEPTH out of range");
      end
      if (OPS_W != $bits(win_op)) begin : g_bad_width
         $error("sfg_window_scan: op vector width mismatch");
      end
   endgenerate

   logic [OP_W-1:0] slot_op [WIN_DEPTH];

   genvar g;
   generate
      for (g = 0; g < WIN_DEPTH; g++) begin : g_slot
         assign slot_op[g] = win_op[g*OP_W +: OP_W];
      end
   endgenerate

   always_comb begin
      logic trap_seen, ctr_seen, lr_seen, stop;
      scan      = '0;
      trap_seen = 1'b0;
      ctr_seen  = 1'b0;
      lr_seen   = 1'b0;
      stop      = 1'b0;
      for (int i = 0; i < WIN_DEPTH; i++) begin
         if (!stop && win_valid[i]) begin
            case (slot_op[i])
               OP_BSELF: begin
                  scan.hang = 1'b1;
                  stop      = 1'b1;
               end
               OP_BCTR: begin
                  scan.found   = 1'b1;
                  scan.use_ctr = 1'b1;
                  scan.blocked = trap_seen | ctr_seen;
                  stop         = 1'b1;
               end
               OP_BLR: begin
                  scan.found   = 1'b1;
                  scan.use_ctr = 1'b0;
                  scan.blocked = trap_seen | lr_seen;
                  stop         = 1'b1;
               end
               OP_TRAP:           trap_seen = 1'b1;
               OP_MTCTR, OP_MFCTR: ctr_seen  = 1'b1;
               OP_MTLR:           lr_seen   = 1'b1;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/sfg_region_lookup.sv
module sfg_region_lookup #(
   parameter int                             ADDR_W      = 16,
   parameter int                             NUM_REGIONS = 4,
   parameter logic [NUM_REGIONS*ADDR_W-1:0]  RGN_BASE    = '0,
   parameter logic [NUM_REGIONS*ADDR_W-1:0]  RGN_LIMIT   = '1,
   parameter logic [NUM_REGIONS-1:0]         RGN_GUARD   = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              guarded,
   output logic              invalid
);
   generate
      if (NUM_REGIONS < 1 || NUM_REGIONS > 32) begin : g_bad_regions
         $error("sfg_region_lookup: NUM_REGIONS out of range");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("sfg_region_lookup: ADDR_W too small");
      end
   endgenerate

   logic [NUM_REGIONS-1:0] hit;

   genvar r;
   generate
      for (r = 0; r < NUM_REGIONS; r++) begin : g_rgn
         localparam logic [ADDR_W-1:0] BASE_R  = RGN_BASE[r*ADDR_W +: ADDR_W];
         localparam logic [ADDR_W-1:0] SPAN_R  =
            RGN_LIMIT[r*ADDR_W +: ADDR_W] - RGN_BASE[r*ADDR_W +: ADDR_W];
         logic [ADDR_W-1:0] offset;
         assign offset = addr - BASE_R;
         assign hit[r] = (offset <= SPAN_R);
      end
   endgenerate

   always_comb begin
      guarded = 1'b0;
      invalid = 1'b1;
      for (int k = NUM_REGIONS - 1; k >= 0; k--) begin
         if (hit[k]) begin
            guarded = RGN_GUARD[k];
            invalid = 1'b0;
         end
      end
   end
endmodule

// File: rtl/sfg_mchk_track.sv
module sfg_mchk_track (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic issue_invalid,
   input  logic exec_commit,
   output logic mchk_pend,
   output logic mchk_raise
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mchk_pend  <= 1'b0;
         mchk_raise <= 1'b0;
      end else if (flush) begin
         mchk_pend  <= 1'b0;
         mchk_raise <= 1'b0;
      end else begin
         mchk_raise <= exec_commit & mchk_pend;
         if (issue_invalid)
            mchk_pend <= 1'b1;
         else if (exec_commit)
            mchk_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/sfg_gate.sv
module sfg_gate
   import sfg_pkg::*;
#(
   parameter int                             ADDR_W      = 16,
   parameter int                             WIN_DEPTH   = 4,
   parameter int                             NUM_REGIONS = 4,
   parameter logic [NUM_REGIONS*ADDR_W-1:0]  RGN_BASE    =
      {16'h7000, 16'h2000, 16'h1000, 16'h0000},
   parameter logic [NUM_REGIONS*ADDR_W-1:0]  RGN_LIMIT   =
      {16'hFFFF, 16'h7FFF, 16'h10FF, 16'h0FFF},
   parameter logic [NUM_REGIONS-1:0]         RGN_GUARD   = 4'b1010
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush,
   input  logic [WIN_DEPTH-1:0]      win_valid,
   input  logic [WIN_DEPTH*OP_W-1:0] win_op,
   input  logic [ADDR_W-1:0]         seq_addr,
   input  logic [ADDR_W-1:0]         ctr_val,
   input  logic [ADDR_W-1:0]         lr_val,
   input  logic                      exec_commit,
   output logic                      fetch_req,
   output logic [ADDR_W-1:0]         fetch_addr,
   output logic                      fetch_indirect,
   output logic                      stall,
   output logic                      hang,
   output logic                      mchk_pend,
   output logic                      mchk_raise
);
   generate
      if (WIN_DEPTH < 1) begin : g_bad_win
         $error("sfg_gate: WIN_DEPTH must be at least 1");
      end
   endgenerate

   sfg_scan_t         scan;
   logic [ADDR_W-1:0] cand_addr;
   logic              cand_guarded, cand_invalid;
   logic              nxt_req, nxt_ind, nxt_stall, nxt_hang;

   sfg_window_scan #(.WIN_DEPTH(WIN_DEPTH)) u_scan (
      .win_valid (win_valid),
      .win_op    (win_op),
      .scan      (scan)
   );

   always_comb begin
      if (scan.found) cand_addr = scan.use_ctr ? ctr_val : lr_val;
      else            cand_addr = seq_addr;
   end

   sfg_region_lookup #(
      .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
      .RGN_BASE(RGN_BASE), .RGN_LIMIT(RGN_LIMIT), .RGN_GUARD(RGN_GUARD)
   ) u_lookup (
      .addr    (cand_addr),
      .guarded (cand_guarded),
      .invalid (cand_invalid)
   );

   always_comb begin
      nxt_req   = 1'b0;
      nxt_ind   = 1'b0;
      nxt_stall = 1'b0;
      nxt_hang  = 1'b0;
      if (scan.hang) begin
         nxt_hang = 1'b1;
      end else if (scan.found && scan.blocked) begin
         nxt_stall = 1'b1;
      end else if (cand_guarded) begin
         nxt_stall = 1'b1;
      end else begin
         nxt_req = 1'b1;
         nxt_ind = scan.found;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_req      <= 1'b0;
         fetch_addr     <= '0;
         fetch_indirect <= 1'b0;
         stall          <= 1'b0;
         hang           <= 1'b0;
      end else if (flush) begin
         fetch_req      <= 1'b0;
         fetch_indirect <= 1'b0;
         stall          <= 1'b0;
         hang           <= 1'b0;
      end else begin
         fetch_req      <= nxt_req;
         fetch_addr     <= cand_addr;
         fetch_indirect <= nxt_ind;
         stall          <= nxt_stall;
         hang           <= nxt_hang;
      end
   end

   sfg_mchk_track u_mchk (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush         (flush),
      .issue_invalid (nxt_req & cand_invalid),
      .exec_commit   (exec_commit),
      .mchk_pend     (mchk_pend),
      .mchk_raise    (mchk_raise)
   );

   logic out_guarded, out_invalid;
   sfg_region_lookup #(
      .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
      .RGN_BASE(RGN_BASE), .RGN_LIMIT(RGN_LIMIT), .RGN_GUARD(RGN_GUARD)
   ) u_out_lookup (
      .addr    (fetch_addr),
      .guarded (out_guarded),
      .invalid (out_invalid)
   );

   AST_NO_GUARDED_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> !out_guarded); // R2
   AST_INDIRECT_FROM_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_indirect) |->
         (fetch_addr == $past(ctr_val) || fetch_addr == $past(lr_val))); // R3
   AST_HANG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      hang |-> (!fetch_req && !stall)); // R8
   AST_INVALID_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && out_invalid) |-> mchk_pend); // R10
   AST_RAISE_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      mchk_raise |-> $past(mchk_pend)); // R11
   AST_FLUSH_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!fetch_req && !stall && !hang && !mchk_pend)); // R12
endmodule

// File: tb/sfg_gate_tb.sv
module sfg_gate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [3:0]  win_valid = '0;
   logic [15:0] win_op = '0;
   logic [15:0] seq_addr = 16'h0200;
   logic [15:0] ctr_val = 16'h2040;
   logic [15:0] lr_val = 16'h0100;
   logic        exec_commit = 1'b0;
   logic        fetch_req, fetch_indirect, stall, hang, mchk_pend, mchk_raise;
   logic [15:0] fetch_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   sfg_gate u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .win_valid(win_valid),
      .win_op(win_op), .seq_addr(seq_addr), .ctr_val(ctr_val), .lr_val(lr_val),
      .exec_commit(exec_commit), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_indirect(fetch_indirect), .stall(stall), .hang(hang),
      .mchk_pend(mchk_pend), .mchk_raise(mchk_raise)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic ref_guarded(input logic [15:0] a);
      if (a <= 16'h0FFF) return 1'b0;
      if (a <= 16'h10FF) return 1'b1;
      if (a <  16'h2000) return 1'b0;
      if (a <= 16'h7FFF) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic ref_invalid(input logic [15:0] a);
      return (a > 16'h10FF && a < 16'h2000);
   endfunction

   // expected {req, indirect, stall, hang, addr}
   function automatic logic [19:0] ref_decide(input logic [3:0] v, input logic [15:0] ops);
      logic tr, cs, ls, rq, ind, st, hg;
      logic [15:0] a;
      tr = 0; cs = 0; ls = 0; rq = 0; ind = 0; st = 0; hg = 0;
      a = seq_addr;
      for (int i = 0; i < 4; i++) begin
         logic [3:0] op;
         op = ops[i*4 +: 4];
         if (v[i]) begin
            if (op == 4'd7) begin hg = 1; break; end
            if (op == 4'd1 || op == 4'd2) begin
               a = (op == 4'd1) ? ctr_val : lr_val;
               ind = 1;
               st = tr | ((op == 4'd1) ? cs : ls);
               break;
            end
            if (op == 4'd6) tr = 1;
            if (op == 4'd3 || op == 4'd4) cs = 1;
            if (op == 4'd5) ls = 1;
         end
      end
      if (hg) begin ind = 0; st = 0; end
      else if (!st && ref_guarded(a)) begin st = 1; ind = 0; end
      else if (!st) rq = 1;
      else ind = 0;
      return {rq, ind, st, hg, a};
   endfunction

   task automatic step_check(input string tag, input logic [3:0] v, input logic [15:0] ops);
      logic [19:0] e;
      win_valid = v;
      win_op    = ops;
      e = ref_decide(v, ops);
      @(negedge clk);
      check({tag, " req"},   32'(fetch_req),      32'(e[19]));
      check({tag, " stall"}, 32'(stall),          32'(e[17]));
      check({tag, " hang"},  32'(hang),           32'(e[16]));
      if (e[19]) begin
         check({tag, " ind"},  32'(fetch_indirect), 32'(e[18]));
         check({tag, " addr"}, 32'(fetch_addr),     32'(e[15:0]));
      end
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R13 reset state
      check("R13 req", 32'(fetch_req), 0);
      check("R13 stall", 32'(stall), 0);
      check("R13 hang", 32'(hang), 0);
      check("R13 pend", 32'(mchk_pend), 0);
      check("R13 raise", 32'(mchk_raise), 0);
      rst_n = 1'b1;

      // R1 R3-R9: exhaustive sweep of all-valid windows over codes 0..8
      for (int n = 0; n < 6561; n++) begin
         int t;
         logic [15:0] ops;
         t = n;
         for (int s = 0; s < 4; s++) begin ops[s*4 +: 4] = 4'(t % 9); t = t / 9; end
         step_check("R1_R3_R4_R5_R6_R7_R8 sweep", 4'hF, ops);
      end

      // R9: valid-bit sweep, youngest slot a branch-to-count
      for (int v = 0; v < 16; v++) begin
         for (int n = 0; n < 729; n++) begin
            int t;
            logic [15:0] ops;
            t = n;
            for (int s = 0; s < 3; s++) begin ops[s*4 +: 4] = 4'(t % 9); t = t / 9; end
            ops[15:12] = 4'd1;
            step_check("R9 valid sweep", 4'(v), ops);
         end
      end

      // R2: guarded indirect targets and guarded sequential addresses
      ctr_val = 16'h1004; lr_val = 16'h9000;
      step_check("R2 guarded ctr", 4'h1, 16'h0001);
      step_check("R2 guarded lr",  4'h1, 16'h0002);
      seq_addr = 16'h1000;
      step_check("R2 seq into guarded", 4'h0, 16'h0000);
      seq_addr = 16'hFFFF;
      step_check("R2 top guarded", 4'h0, 16'h0000);
      // R10: first-match priority in overlap, last open code address
      seq_addr = 16'h7800;
      step_check("R10 overlap open", 4'h0, 16'h0000);
      seq_addr = 16'h0FFF;
      step_check("R10 last code addr", 4'h0, 16'h0000);
      seq_addr = 16'h8000;
      step_check("R10 above overlap", 4'h0, 16'h0000);

      // R10 R11: invalid fetch records, commit raises
      seq_addr = 16'h1800; win_valid = '0;
      @(negedge clk);
      check("R10 invalid fetched", 32'(fetch_req), 1);
      check("R10 pend set", 32'(mchk_pend), 1);
      seq_addr = 16'h0200; exec_commit = 1'b1;
      @(negedge clk);
      check("R11 raise", 32'(mchk_raise), 1);
      check("R11 pend clear", 32'(mchk_pend), 0);
      exec_commit = 1'b0;
      @(negedge clk);
      check("R11 raise one cycle", 32'(mchk_raise), 0);
      exec_commit = 1'b1;
      @(negedge clk);
      check("R11 no raise without pend", 32'(mchk_raise), 0);
      exec_commit = 1'b0;

      // R12: flush drops pending check and quiets outputs
      seq_addr = 16'h1800;
      @(negedge clk);
      check("R12 pend before flush", 32'(mchk_pend), 1);
      seq_addr = 16'h0200; flush = 1'b1; exec_commit = 1'b1;
      @(negedge clk);
      check("R12 pend dropped", 32'(mchk_pend), 0);
      check("R12 no raise", 32'(mchk_raise), 0);
      check("R12 req quiet", 32'(fetch_req), 0);
      check("R12 stall quiet", 32'(stall), 0);
      flush = 1'b0; exec_commit = 1'b0;
      @(negedge clk);
      check("R12 no late raise", 32'(mchk_raise), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule